// File: doc/BRIEF.md
# Two-Pool Virtual Channel Selector with One-Way Escape Fallback

This unit sits at a router input and picks the output port and virtual channel for a packet's head flit. Every output port offers two kinds of virtual channel. Adaptive channels may be taken on any output port that moves the packet closer to its destination. Escape channels may only be taken on the port chosen by deterministic dimension-order routing. The unit tries the adaptive channels first. When no adaptive channel is free on any productive port, it falls back to an escape channel on the dimension-order port. Each packet carries a sticky flag that records this fallback. Once the flag is set, the packet is held to escape channels on the dimension-order route for the rest of its trip. This keeps the escape network free of cyclic dependences.

A head flit arrives on a valid/ready request stream together with its productive-port mask, its dimension-order port and its incoming escape flag. A transfer takes place in a cycle where `hd_valid` and `hd_ready` are both high. The decision is registered and appears one cycle later on a valid/ready grant stream, together with the updated flag that the packet header carries onward. A grant is held, with its fields unchanged, until `gr_ready` takes it. While a grant is waiting, no new request is taken. Per-channel credit availability is given as flat free-flag vectors. When no eligible channel exists, `stall` is raised and the request waits at the input.

Top module: `vc2ph_select`

## Requirements
- R1: After reset, `gr_valid` is 0. With `hd_valid` low, `stall` is 0 and nothing is granted.
- R2: If the incoming escape flag is 0 and some productive port has a free adaptive channel, the grant goes to the lowest-numbered such port. On that port it takes the lowest-numbered free adaptive channel, reported as `gr_vc` = adaptive index (0..NADP-1), with `gr_escaped` = 0.
- R3: If the incoming escape flag is 0 and no productive port has a free adaptive channel, the grant goes to port `hd_dor`. It takes the lowest free escape channel there, reported as `gr_vc` = NADP + escape index, with `gr_escaped` = 1.
- R4: If the incoming escape flag is 1, only escape channels on port `hd_dor` are considered, even when adaptive channels are free. The grant always has `gr_escaped` = 1 and `gr_vc` >= NADP.
- R5: When no eligible channel exists, `stall` is 1 and `hd_ready` is 0. No grant is produced, and the grant outputs stay unchanged.
- R6: An accepted request appears on `gr_valid`/`gr_port`/`gr_vc`/`gr_escaped` on the clock edge that accepts it. It is therefore visible for the whole following cycle.
- R7: While `gr_valid` is 1 and `gr_ready` is 0, the grant fields stay stable and `hd_ready` is 0.
- R8: Free adaptive channels on ports outside the productive mask are never granted. If such channels are the only free adaptive ones, the R3 fallback applies.
- R9: Free-flag layout: adaptive channel v of port p is bit p*NADP+v of `adp_free`. Escape channel e of port p is bit p*NESC+e of `esc_free`. A set bit means the channel is free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hd_valid | input | 1 | Head-flit request present |
| hd_ready | output | 1 | Request accepted this cycle |
| hd_prod | input | NPORT | Productive output ports of the packet |
| hd_dor | input | PW | Dimension-order output port |
| hd_escaped | input | 1 | Packet already on escape channels |
| adp_free | input | NPORT*NADP | Adaptive channel free flags |
| esc_free | input | NPORT*NESC | Escape channel free flags |
| gr_valid | output | 1 | Grant present |
| gr_ready | input | 1 | Downstream takes the grant |
| gr_port | output | PW | Granted output port |
| gr_vc | output | VW | Granted channel: adaptive index, or NADP plus escape index |
| gr_escaped | output | 1 | Updated sticky escape flag |
| stall | output | 1 | Request present but no eligible channel |

## Verification
A wrong choice between the two pools shows one cycle after acceptance. It appears as a `gr_vc` below NADP on a packet whose flag was set, or as an escape grant while a productive adaptive channel was free. A wrong priority shows in the same cycle as a higher port or channel index than the lowest free one. A wrong availability decision shows at once, in the same cycle, on `stall` and `hd_ready`, before any clock edge. A fault in the grant-holding logic shows in the first cycle of back-pressure, as a field that changes while `gr_ready` is low.

// File: rtl/vc2ph_pkg.sv
package vc2ph_pkg;
  typedef enum logic [1:0] {
    POOL_NONE  = 2'd0,
    POOL_ADAPT = 2'd1,
    POOL_ESC   = 2'd2
  } pool_e;
endpackage

// File: rtl/lowbit_pick.sv
module lowbit_pick #(
  parameter int W = 4
) (
  input  logic [W-1:0]                   vec,
  output logic                           found,
  output logic [(W > 1 ? $clog2(W) : 1)-1:0] idx
);
  localparam int IW = (W > 1) ? $clog2(W) : 1;

  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/adapt_scan.sv
module adapt_scan #(
  parameter int NPORT = 4,
  parameter int NADP  = 2
) (
  input  logic [NPORT-1:0]                          prod,
  input  logic [NPORT*NADP-1:0]                     free,
  output logic                                      found,
  output logic [(NPORT > 1 ? $clog2(NPORT) : 1)-1:0] port,
  output logic [(NADP > 1 ? $clog2(NADP) : 1)-1:0]   vc
);
  localparam int PW = (NPORT > 1) ? $clog2(NPORT) : 1;
  localparam int AW = (NADP > 1) ? $clog2(NADP) : 1;

  logic [NPORT-1:0] has_free;
  logic [AW-1:0]    port_vc [NPORT];
  logic [NPORT-1:0] eligible;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    lowbit_pick #(.W(NADP)) u_vc (
      .vec   (free[p*NADP +: NADP]),
      .found (has_free[p]),
      .idx   (port_vc[p])
    );
  end

  assign eligible = prod & has_free;

  lowbit_pick #(.W(NPORT)) u_port (
    .vec   (eligible),
    .found (found),
    .idx   (port)
  );

  always_comb begin
    vc = '0;
    for (int p = 0; p < NPORT; p++) begin
      if (PW'(p) == port) vc = port_vc[p];
    end
  end
endmodule

// File: rtl/esc_pick.sv
module esc_pick #(
  parameter int NPORT = 4,
  parameter int NESC  = 1
) (
  input  logic [(NPORT > 1 ? $clog2(NPORT) : 1)-1:0] dor,
  input  logic [NPORT*NESC-1:0]                     free,
  output logic                                      found,
  output logic [(NESC > 1 ? $clog2(NESC) : 1)-1:0]   vc
);
  localparam int PW = (NPORT > 1) ? $clog2(NPORT) : 1;

  logic [NESC-1:0] slice;

  always_comb begin
    slice = '0;
    for (int p = 0; p < NPORT; p++) begin
      if (PW'(p) == dor) slice = free[p*NESC +: NESC];
    end
  end

  lowbit_pick #(.W(NESC)) u_esc (
    .vec   (slice),
    .found (found),
    .idx   (vc)
  );
endmodule

// File: rtl/vc2ph_select.sv
module vc2ph_select #(
  parameter int NPORT = 4,
  parameter int NADP  = 2,
  parameter int NESC  = 1
) (
  input  logic                                             clk,
  input  logic                                             rst_n,
  input  logic                                             hd_valid,
  output logic                                             hd_ready,
  input  logic [NPORT-1:0]                                 hd_prod,
  input  logic [(NPORT > 1 ? $clog2(NPORT) : 1)-1:0]        hd_dor,
  input  logic                                             hd_escaped,
  input  logic [NPORT*NADP-1:0]                            adp_free,
  input  logic [NPORT*NESC-1:0]                            esc_free,
  output logic                                             gr_valid,
  input  logic                                             gr_ready,
  output logic [(NPORT > 1 ? $clog2(NPORT) : 1)-1:0]        gr_port,
  output logic [((NADP + NESC) > 1 ? $clog2(NADP + NESC) : 1)-1:0] gr_vc,
  output logic                                             gr_escaped,
  output logic                                             stall
);
  import vc2ph_pkg::*;

  localparam int PW  = (NPORT > 1) ? $clog2(NPORT) : 1;
  localparam int NVC = NADP + NESC;
  localparam int VW  = (NVC > 1) ? $clog2(NVC) : 1;
  localparam int AW  = (NADP > 1) ? $clog2(NADP) : 1;
  localparam int EW  = (NESC > 1) ? $clog2(NESC) : 1;

  logic          a_found, e_found;
  logic [PW-1:0] a_port;
  logic [AW-1:0] a_vc;
  logic [EW-1:0] e_vc;
  pool_e         sel_pool;
  logic [PW-1:0] nxt_port;
  logic [VW-1:0] nxt_vc;
  logic          out_free, accept;

  adapt_scan #(.NPORT(NPORT), .NADP(NADP)) u_adapt (
    .prod  (hd_prod),
    .free  (adp_free),
    .found (a_found),
    .port  (a_port),
    .vc    (a_vc)
  );

  esc_pick #(.NPORT(NPORT), .NESC(NESC)) u_esc (
    .dor   (hd_dor),
    .free  (esc_free),
    .found (e_found),
    .vc    (e_vc)
  );

  always_comb begin
    if (!hd_escaped && a_found) sel_pool = POOL_ADAPT;
    else if (e_found)           sel_pool = POOL_ESC;
    else                        sel_pool = POOL_NONE;
  end

  always_comb begin
    nxt_port = hd_dor;
    nxt_vc   = VW'(NADP) + VW'(e_vc);
    if (sel_pool == POOL_ADAPT) begin
      nxt_port = a_port;
      nxt_vc   = VW'(a_vc);
    end
  end

  assign out_free = !gr_valid || gr_ready;
  assign hd_ready = out_free && (sel_pool != POOL_NONE);
  assign stall    = hd_valid && (sel_pool == POOL_NONE);
  assign accept   = hd_valid && hd_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gr_valid   <= 1'b0;
      gr_port    <= '0;
      gr_vc      <= '0;
      gr_escaped <= 1'b0;
    end else if (accept) begin
      gr_valid   <= 1'b1;
      gr_port    <= nxt_port;
      gr_vc      <= nxt_vc;
      gr_escaped <= (sel_pool == POOL_ESC);
    end else if (gr_ready) begin
      gr_valid   <= 1'b0;
    end
  end

  // R4: an escaped packet never receives an adaptive channel
  assert_sticky_escape_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && hd_escaped) |=> (gr_escaped && gr_vc >= VW'(NADP)));

  // R3: escape grants follow the dimension-order port
  assert_escape_on_dor_R3: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (gr_vc < VW'(NADP) || gr_port == $past(hd_dor)));

  // R8: adaptive grants only on productive ports
  assert_adapt_productive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (gr_vc >= VW'(NADP) || (($past(hd_prod) >> gr_port) & 1) == 1));

  // R7: held grant stays stable under back-pressure
  assert_hold_grant_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (gr_valid && !gr_ready) |=> (gr_valid && $stable(gr_port) && $stable(gr_vc)
                                 && $stable(gr_escaped)));

  // R5: stall excludes acceptance and leaves the output alone
  assert_stall_no_take_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && gr_ready) |=> !gr_valid);

  // R2: a flagged grant is always an escape channel
  assert_flag_matches_pool_R2: assert property (@(posedge clk) disable iff (!rst_n)
    gr_valid |-> (gr_escaped == (gr_vc >= VW'(NADP))));
endmodule

// File: tb/tb_vc2ph_select.sv
module tb_vc2ph_select;
  localparam int CLK_PERIOD = 10;
  localparam int NPORT = 4;
  localparam int NADP  = 2;
  localparam int NESC  = 1;
  localparam int PW = 2;
  localparam int VW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hd_valid = 1'b0;
  logic hd_ready;
  logic [NPORT-1:0] hd_prod = '0;
  logic [PW-1:0] hd_dor = '0;
  logic hd_escaped = 1'b0;
  logic [NPORT*NADP-1:0] adp_free = '0;
  logic [NPORT*NESC-1:0] esc_free = '0;
  logic gr_valid;
  logic gr_ready = 1'b1;
  logic [PW-1:0] gr_port;
  logic [VW-1:0] gr_vc;
  logic gr_escaped;
  logic stall;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vc2ph_select #(.NPORT(NPORT), .NADP(NADP), .NESC(NESC)) dut (
    .clk(clk), .rst_n(rst_n), .hd_valid(hd_valid), .hd_ready(hd_ready),
    .hd_prod(hd_prod), .hd_dor(hd_dor), .hd_escaped(hd_escaped),
    .adp_free(adp_free), .esc_free(esc_free), .gr_valid(gr_valid),
    .gr_ready(gr_ready), .gr_port(gr_port), .gr_vc(gr_vc),
    .gr_escaped(gr_escaped), .stall(stall)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Reference model built from the requirements
  task automatic model(input logic [NPORT-1:0] prod, input logic [PW-1:0] dor,
                       input logic esc, input logic [NPORT*NADP-1:0] af,
                       input logic [NPORT*NESC-1:0] ef,
                       output logic ok, output int port, output int vc, output logic eflag);
    ok = 1'b0; port = 0; vc = 0; eflag = 1'b0;
    if (!esc) begin
      for (int p = 0; p < NPORT && !ok; p++) begin
        if (prod[p]) begin
          for (int v = 0; v < NADP && !ok; v++) begin
            if (af[p*NADP+v]) begin ok = 1'b1; port = p; vc = v; end
          end
        end
      end
    end
    if (!ok) begin
      for (int e = 0; e < NESC && !ok; e++) begin
        if (ef[int'(dor)*NESC+e]) begin
          ok = 1'b1; port = int'(dor); vc = NADP + e; eflag = 1'b1;
        end
      end
    end
  endtask

  task automatic apply(input logic [NPORT-1:0] prod, input logic [PW-1:0] dor,
                       input logic esc, input logic [NPORT*NADP-1:0] af,
                       input logic [NPORT*NESC-1:0] ef, input string tag);
    logic ok, ef_x;
    int port, vc;
    model(prod, dor, esc, af, ef, ok, port, vc, ef_x);
    hd_prod = prod; hd_dor = dor; hd_escaped = esc;
    adp_free = af; esc_free = ef; hd_valid = 1'b1; gr_ready = 1'b1;
    #1;
    chk(stall == !ok, {tag, " R5 stall"}, int'(stall), int'(!ok));
    chk(hd_ready == ok, {tag, " R5 ready"}, int'(hd_ready), int'(ok));
    @(negedge clk);
    hd_valid = 1'b0;
    chk(gr_valid == ok, {tag, " R6 valid"}, int'(gr_valid), int'(ok));
    if (ok) begin
      chk(int'(gr_port) == port, {tag, " port"}, int'(gr_port), port);
      chk(int'(gr_vc) == vc, {tag, " vc"}, int'(gr_vc), vc);
      chk(gr_escaped == ef_x, {tag, " flag"}, int'(gr_escaped), int'(ef_x));
      if (esc) chk(int'(gr_vc) >= NADP, "R4 escaped got adaptive", int'(gr_vc), NADP);
    end
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(gr_valid == 1'b0, "R1 gr_valid", int'(gr_valid), 0);
    chk(stall == 1'b0, "R1 stall", int'(stall), 0);

    // R2: lowest productive port with free adaptive, lowest vc (port2 vc1)
    apply(4'b1100, 2'd3, 1'b0, 8'b1110_1000, 4'b1111, "R2");
    // R8: free adaptive only on non-productive ports -> fallback R3
    apply(4'b0101, 2'd2, 1'b0, 8'b1100_1100, 4'b0100, "R8");
    // R3: no adaptive at all -> escape on dor port 1
    apply(4'b1111, 2'd1, 1'b0, 8'b0000_0000, 4'b0010, "R3");
    // R4: escaped with adaptive free -> escape on dor
    apply(4'b1111, 2'd0, 1'b1, 8'b1111_1111, 4'b0001, "R4");
    // R4/R5: escaped and escape busy -> stall despite free adaptive
    apply(4'b1111, 2'd3, 1'b1, 8'b1111_1111, 4'b0111, "R4 stall");
    // R5: nothing free
    apply(4'b0011, 2'd0, 1'b0, 8'b0000_0000, 4'b0000, "R5");
    // R9: bit layout, port3 vc0 is bit 6
    apply(4'b1000, 2'd3, 1'b0, 8'b0100_0000, 4'b0000, "R9");

    // R7: back-pressure holds grant and blocks input
    hd_prod = 4'b0001; hd_dor = 2'd0; hd_escaped = 1'b0;
    adp_free = 8'b0000_0010; esc_free = 4'b0000; hd_valid = 1'b1; gr_ready = 1'b0;
    @(negedge clk);
    hd_prod = 4'b0010; hd_dor = 2'd1; adp_free = 8'b0000_0100;
    #1;
    chk(hd_ready == 1'b0, "R7 ready held low", int'(hd_ready), 0);
    @(negedge clk);
    chk(gr_valid && gr_port == 2'd0 && gr_vc == 2'd1, "R7 grant stable",
        int'(gr_vc), 1);
    gr_ready = 1'b1;
    @(negedge clk);
    chk(gr_valid && gr_port == 2'd1 && gr_vc == 2'd0, "R6 next grant",
        int'(gr_port), 1);
    hd_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);

    // Random vectors
    for (int k = 0; k < 400; k++) begin
      logic [NPORT-1:0] pr;
      logic [NPORT*NADP-1:0] af;
      logic [NPORT*NESC-1:0] ef;
      pr = NPORT'($urandom);
      af = (NPORT*NADP)'($urandom & $urandom & $urandom);
      ef = NPORT'($urandom);
      apply(pr, PW'($urandom), ($urandom % 3) == 0, af, ef, "rand R2/R3/R4");
    end

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule